// File: doc/BRIEF.md
# Dual-Channel Circular Ring Transfer Engine

This block carries time-slot bytes for two B-channels between a word-addressed memory and a pair of byte lanes. Each 32-bit memory word carries one byte of each channel: channel 0 in bits 7:0, channel 1 in bits 15:8. On every frame-sync strobe the engine stores one received word into a receive ring and moves on to the next transmit word, which it has fetched from a transmit ring before the strobe arrives. Each ring has a programmable first word, middle word and last word. After the last word the engine goes back to the first word with no gap.

Software sets the three addresses of each ring and then writes the run bit. While the engine runs it posts status bits when a ring passes its middle word and when it reaches its last word. If a status bit is still set when the same event comes round again, the engine sets a sticky overrun bit. Status bits are cleared by writing ones to them. An interrupt level is raised for every status bit that is set and enabled in the mask. The memory is a single synchronous word port. A write happens in the cycle it is requested. Read data appears one cycle after the request.

Frame-sync strobes must be at least three cycles apart. A strobe that arrives while a transmit fetch is still in progress is dropped.

Top module: `ring_dma_engine`

## Requirements
- R1: After reset, both transmit lanes read 8'hFF, irq is 0, and the status, mask, control and both current-address registers read 0.
- R2: Writing 1 to bit 0 of the control register (index 0) while stopped starts the engine. Both current addresses load their ring's first word and the first transmit word is prefetched, so the transmit current address then reads first+1. Writing 0 stops the engine. While stopped, a strobe writes no memory and moves no address.
- R3: On each strobe while running, the word {16'h0, ch1 byte, ch0 byte} is written at the receive current address, and that address then advances.
- R4: At strobe k after start, tx_ch0 and tx_ch1 present bits 7:0 and 15:8 of the transmit word at ring index k. The next word is fetched within two cycles after the strobe.
- R5: A current address that reaches its ring's last word continues at the first word.
- R6: Status bits are set when the ring word at the middle or last address is written (receive) or fetched (transmit). Bit 0 is receive middle, bit 1 is receive last, bit 2 is transmit middle and bit 3 is transmit last.
- R7: Status bit 4 (receive) or bit 5 (transmit) is set when a middle or last event of that direction recurs while its bit is still set. Bits 4 and 5 stay set until cleared.
- R8: Writing the status register (index 2) clears each bit written as 1. Bits written as 0 are unchanged.
- R9: irq is high exactly when some status bit is set and its mask bit (mask register index 1, same bit positions) is 1.
- R10: Register indices: 3, 4, 5, 6 are transmit first, middle, last and current. Indices 7, 8, 9, 10 are the same four for receive. The current addresses are read-only, and the other addresses read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| fsync | input | 1 | Frame-sync strobe, one cycle wide |
| rx_ch0 | input | 8 | Received byte, channel 0 |
| rx_ch1 | input | 8 | Received byte, channel 1 |
| tx_ch0 | output | 8 | Transmit byte, channel 0 |
| tx_ch1 | output | 8 | Transmit byte, channel 1 |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write when 1, read when 0 |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid one cycle after a read request |
| irq | output | 1 | Level interrupt |

## Verification
The overrun bits are the hardest thing to reach from the ports. The same ring event has to come round a second time while its first status bit is still pending, and the two rings have different sizes and event phases. The stimulus first clears only the receive-middle bit. It then keeps strobing until the receive ring has wrapped once with its last bit still set, and the transmit ring has passed its middle word a second time. The expected status value is checked at each stage. A table of strobes walks both rings past their wrap points, so transmit lane data is checked across the wrap and receive memory is checked after it has been overwritten.

// File: rtl/rde_pkg.sv
package rde_pkg;
    localparam int LANE_W  = 8;
    localparam int WORD_W  = 32;
    localparam int NDIR    = 2;
    localparam int DIR_RX  = 0;
    localparam int DIR_TX  = 1;
    localparam int NSTAT   = 3 * NDIR;
    localparam int REG_AW  = 4;

    typedef enum logic [REG_AW-1:0] {
        RG_CTRL     = 4'd0,
        RG_MASK     = 4'd1,
        RG_STATUS   = 4'd2,
        RG_TX_FIRST = 4'd3,
        RG_TX_MID   = 4'd4,
        RG_TX_LAST  = 4'd5,
        RG_TX_CUR   = 4'd6,
        RG_RX_FIRST = 4'd7,
        RG_RX_MID   = 4'd8,
        RG_RX_LAST  = 4'd9,
        RG_RX_CUR   = 4'd10
    } reg_id_e;

    typedef struct packed {
        logic mid;
        logic last;
    } ring_evt_t;

    function automatic logic [WORD_W-1:0] pack_lanes(input logic [LANE_W-1:0] c0,
                                                     input logic [LANE_W-1:0] c1);
        return {{(WORD_W-2*LANE_W){1'b0}}, c1, c0};
    endfunction
endpackage

// File: rtl/rde_ring.sv
module rde_ring
    import rde_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] first_a,
    input  logic [AW-1:0] mid_a,
    input  logic [AW-1:0] last_a,
    output logic [AW-1:0] cur,
    output ring_evt_t     ev
);
    always_comb begin
        ev.mid  = step && (cur == mid_a);
        ev.last = step && (cur == last_a);
    end

    always_ff @(posedge clk) begin
        if (rst)       cur <= '0;
        else if (load) cur <= first_a;
        else if (step) cur <= (cur == last_a) ? first_a : cur + 1'b1;
    end

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!load && !step) |=> $stable(cur));
    p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (step && !load && cur == last_a) |=> (cur == $past(first_a)));
endmodule

// File: rtl/rde_regs.sv
module rde_regs
    import rde_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [REG_AW-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    input  ring_evt_t         ev      [NDIR],
    input  logic [AW-1:0]     cur     [NDIR],
    output logic              run,
    output logic              run_start,
    output logic [AW-1:0]     first_a [NDIR],
    output logic [AW-1:0]     mid_a   [NDIR],
    output logic [AW-1:0]     last_a  [NDIR],
    output logic              irq
);
    logic [NSTAT-1:0] status, mask, clr_v, set_v;
    logic             unused_hi;

    assign unused_hi = ^wdata[WORD_W-1:AW];
    assign run_start = we && (addr == RG_CTRL) && wdata[0] && !run;
    assign irq       = |(status & mask);

    always_comb begin
        clr_v = (we && addr == RG_STATUS) ? wdata[NSTAT-1:0] : '0;
        set_v = '0;
        for (int d = 0; d < NDIR; d++) begin
            set_v[2*d]      = ev[d].mid;
            set_v[2*d+1]    = ev[d].last;
            set_v[2*NDIR+d] = (ev[d].mid && status[2*d]) || (ev[d].last && status[2*d+1]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run    <= 1'b0;
            mask   <= '0;
            status <= '0;
            for (int d = 0; d < NDIR; d++) begin
                first_a[d] <= '0;
                mid_a[d]   <= '0;
                last_a[d]  <= '0;
            end
        end else begin
            status <= (status & ~clr_v) | set_v;
            if (we) begin
                case (addr)
                    RG_CTRL:     run             <= wdata[0];
                    RG_MASK:     mask            <= wdata[NSTAT-1:0];
                    RG_TX_FIRST: first_a[DIR_TX] <= wdata[AW-1:0];
                    RG_TX_MID:   mid_a[DIR_TX]   <= wdata[AW-1:0];
                    RG_TX_LAST:  last_a[DIR_TX]  <= wdata[AW-1:0];
                    RG_RX_FIRST: first_a[DIR_RX] <= wdata[AW-1:0];
                    RG_RX_MID:   mid_a[DIR_RX]   <= wdata[AW-1:0];
                    RG_RX_LAST:  last_a[DIR_RX]  <= wdata[AW-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            RG_CTRL:     rdata[0]         = run;
            RG_MASK:     rdata[NSTAT-1:0] = mask;
            RG_STATUS:   rdata[NSTAT-1:0] = status;
            RG_TX_FIRST: rdata[AW-1:0]    = first_a[DIR_TX];
            RG_TX_MID:   rdata[AW-1:0]    = mid_a[DIR_TX];
            RG_TX_LAST:  rdata[AW-1:0]    = last_a[DIR_TX];
            RG_TX_CUR:   rdata[AW-1:0]    = cur[DIR_TX];
            RG_RX_FIRST: rdata[AW-1:0]    = first_a[DIR_RX];
            RG_RX_MID:   rdata[AW-1:0]    = mid_a[DIR_RX];
            RG_RX_LAST:  rdata[AW-1:0]    = last_a[DIR_RX];
            RG_RX_CUR:   rdata[AW-1:0]    = cur[DIR_RX];
            default: ;
        endcase
    end

    p_w1c_r8: assert property (@(posedge clk) disable iff (rst)
        (we && addr == RG_STATUS && wdata[0] && !ev[DIR_RX].mid) |=> !status[0]);
    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (status[2*NDIR] && !clr_v[2*NDIR]) |=> status[2*NDIR]);
    p_start_r2: assert property (@(posedge clk) disable iff (rst)
        run_start |=> run);
endmodule

// File: rtl/ring_dma_engine.sv
module ring_dma_engine
    import rde_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              fsync,
    input  logic [LANE_W-1:0] rx_ch0,
    input  logic [LANE_W-1:0] rx_ch1,
    output logic [LANE_W-1:0] tx_ch0,
    output logic [LANE_W-1:0] tx_ch1,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              irq
);
    logic              run, run_start, rd_pend, ld_pend, strobe_ok;
    logic [NDIR-1:0]   step_v;
    logic [AW-1:0]     first_a [NDIR];
    logic [AW-1:0]     mid_a   [NDIR];
    logic [AW-1:0]     last_a  [NDIR];
    logic [AW-1:0]     cur     [NDIR];
    ring_evt_t         ev      [NDIR];
    logic [WORD_W-1:0] tx_word;
    logic              unused_tx;

    assign strobe_ok = fsync && run && !rd_pend && !ld_pend;

    always_comb begin
        step_v         = '0;
        step_v[DIR_RX] = strobe_ok;
        step_v[DIR_TX] = ld_pend;
    end

    rde_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .ev(ev), .cur(cur), .run(run), .run_start(run_start),
        .first_a(first_a), .mid_a(mid_a), .last_a(last_a), .irq(irq)
    );

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        rde_ring #(.AW(AW)) u_ring (
            .clk(clk), .rst(rst), .load(run_start), .step(step_v[d]),
            .first_a(first_a[d]), .mid_a(mid_a[d]), .last_a(last_a[d]),
            .cur(cur[d]), .ev(ev[d])
        );
    end

    assign mem_req   = strobe_ok || rd_pend;
    assign mem_we    = strobe_ok;
    assign mem_addr  = strobe_ok ? cur[DIR_RX] : cur[DIR_TX];
    assign mem_wdata = pack_lanes(rx_ch0, rx_ch1);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_pend <= 1'b0;
            ld_pend <= 1'b0;
            tx_word <= '1;
        end else begin
            rd_pend <= run_start || strobe_ok;
            ld_pend <= rd_pend;
            if (ld_pend) tx_word <= mem_rdata;
        end
    end

    assign tx_ch0    = tx_word[LANE_W-1:0];
    assign tx_ch1    = tx_word[2*LANE_W-1:LANE_W];
    assign unused_tx = ^tx_word[WORD_W-1:2*LANE_W];

    p_fetch_r4: assert property (@(posedge clk) disable iff (rst)
        rd_pend |-> (mem_req && !mem_we && mem_addr == cur[DIR_TX]));
    p_load_r4: assert property (@(posedge clk) disable iff (rst)
        ld_pend |=> (tx_ch0 == $past(mem_rdata[LANE_W-1:0])));
    p_stopped_r2: assert property (@(posedge clk) disable iff (rst)
        !run |-> !(mem_req && mem_we));
    p_rx_word_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_addr == cur[DIR_RX] && mem_wdata[2*LANE_W-1:LANE_W] == rx_ch1));
endmodule

// File: tb/ring_dma_engine_tb.sv
module ring_dma_engine_tb;
    import rde_pkg::*;
    localparam int AW  = 16;
    localparam int TXB = 16'h0040;
    localparam int TXN = 16;
    localparam int RXB = 16'h0080;
    localparam int RXN = 8;
    localparam int NV  = 20;
    localparam logic [15:0] VEC [NV] = '{
        16'h1101, 16'h2202, 16'h3303, 16'h4404, 16'h5505, 16'h6606, 16'h7707,
        16'h8808, 16'h9909, 16'hAA0A, 16'hBB0B, 16'hCC0C, 16'hDD0D, 16'hEE0E,
        16'hF10F, 16'hF210, 16'hF311, 16'hF412, 16'hF513, 16'hF614};

    logic clk = 1'b0, rst = 1'b1, reg_we = 1'b0, fsync = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata, mem_wdata, mem_rdata;
    logic [7:0]  rx_ch0 = '0, rx_ch1 = '0, tx_ch0, tx_ch1;
    logic        mem_req, mem_we, irq;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem [1024];
    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ring_dma_engine #(.AW(AW)) u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .fsync(fsync), .rx_ch0(rx_ch0), .rx_ch1(rx_ch1),
        .tx_ch0(tx_ch0), .tx_ch1(tx_ch1), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq));

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[9:0]];
        end
    end

    function automatic logic [31:0] tx_val(input int i);
        return {16'hA5A5, 8'(8'h30 + i), 8'(8'hC0 ^ i)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic strobe(input logic [15:0] rxw, output logic [15:0] seen);
        @(negedge clk); fsync = 1'b1; rx_ch0 = rxw[7:0]; rx_ch1 = rxw[15:8];
        seen = {tx_ch1, tx_ch0};
        @(negedge clk); fsync = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic strobes(input int n);
        logic [15:0] s;
        for (int i = 0; i < n; i++) strobe(16'h5A00 + 16'(i), s);
    endtask

    task automatic go();
        wr(4'd0, 32'd1);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, keep;
        logic [15:0] seen;
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        for (int i = 0; i < TXN; i++) mem[TXB+i] = tx_val(i);
        for (int i = 0; i < RXN; i++) mem[RXB+i] = 32'hDEAD0000 | i;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        @(negedge clk);
        check("R1 tx lanes", {16'h0, tx_ch1, tx_ch0}, 32'h0000FFFF);
        check("R1 irq", {31'h0, irq}, 32'h0);
        rd(4'd2, d);  check("R1 status", d, 32'h0);
        rd(4'd0, d);  check("R1 ctrl", d, 32'h0);
        rd(4'd6, d);  check("R1 tx cur", d, 32'h0);
        rd(4'd10, d); check("R1 rx cur", d, 32'h0);

        // R10 configuration and readback
        wr(4'd3, TXB); wr(4'd4, TXB + TXN/2 - 1); wr(4'd5, TXB + TXN - 1);
        wr(4'd7, RXB); wr(4'd8, RXB + RXN/2 - 1); wr(4'd9, RXB + RXN - 1);
        rd(4'd4, d); check("R10 tx mid", d, TXB + TXN/2 - 1);
        rd(4'd9, d); check("R10 rx last", d, RXB + RXN - 1);

        // R2 start: prefetch done, addresses loaded
        go();
        rd(4'd6, d);  check("R2 tx cur after prefetch", d, TXB + 1);
        rd(4'd10, d); check("R2 rx cur at start", d, RXB);
        rd(4'd0, d);  check("R2 ctrl run", d, 32'h1);

        // R4 R5 table walk across both wrap points
        for (int k = 0; k < NV; k++) begin
            strobe(VEC[k], seen);
            check(k >= TXN ? "R5 R4 tx lanes after wrap" : "R4 tx lanes",
                  {16'h0, seen}, {16'h0, tx_val(k % TXN)}[31:0] & 32'h0000FFFF);
        end
        for (int j = 0; j < RXN; j++) begin
            int k;
            k = (j < NV - 2*RXN) ? 2*RXN + j : RXN + j;
            check("R3 R5 rx word", mem[RXB+j], {16'h0, VEC[k]});
        end

        // R6 R8 R9 status bits
        wr(4'd0, 32'd0);
        wr(4'd2, 32'h3F);
        go();
        strobes(4);
        rd(4'd2, d); check("R6 rx mid bit0", d, 32'h01);
        check("R9 masked irq low", {31'h0, irq}, 32'h0);
        wr(4'd2, 32'h0);
        rd(4'd2, d); check("R8 zero write no effect", d, 32'h01);
        wr(4'd1, 32'h01);
        check("R9 irq with mask bit0", {31'h0, irq}, 32'h1);
        wr(4'd2, 32'h01);
        rd(4'd2, d); check("R8 clear bit0", d, 32'h0);
        check("R9 irq after clear", {31'h0, irq}, 32'h0);
        strobes(4);
        rd(4'd2, d);  check("R6 rx last and tx mid", d, 32'h06);
        rd(4'd10, d); check("R5 rx cur wrapped", d, RXB);
        rd(4'd6, d);  check("R5 tx cur", d, TXB + 9);

        // R7 overrun
        strobes(8);
        rd(4'd2, d); check("R7 rx overrun", d, 32'h1F);
        strobes(8);
        rd(4'd2, d); check("R7 tx overrun", d, 32'h3F);
        wr(4'd1, 32'h20);
        check("R9 irq from tx overrun", {31'h0, irq}, 32'h1);
        wr(4'd2, 32'h20);
        check("R8 R9 irq after overrun clear", {31'h0, irq}, 32'h0);

        // R2 stopped engine ignores strobes
        wr(4'd0, 32'd0);
        rd(4'd10, d);
        keep = mem[d[9:0]];
        strobe(16'h7777, seen);
        check("R2 stopped no write", mem[d[9:0]], keep);
        rd(4'd10, keep); check("R2 stopped rx cur", keep, d);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule